// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns one mouse event into the five bytes that a serial mouse sends for it, and hands those bytes one per cycle to a byte FIFO feeding a serial channel. An event carries a signed horizontal step, a signed vertical step and the state of three buttons. It is taken in through a valid/ready handshake. The packet leaves through a push strobe with a byte beside it.

The first byte is a header. Its top five bits are fixed. Its low three bits are set for released buttons and cleared for pressed ones. Next come the horizontal step and then the vertical step, each limited to a symmetric range. The vertical step is negated so that moving up gives a positive value. Two zero bytes complete the packet. While a packet is being pushed, the block refuses new events.

Top module: `mouse_pkt_enc`

## Requirements
- R1: Out of reset, `push` is low and `ev_ready` is high.
- R2: Byte 0 of a packet is 8'h87 with bits cleared for pressed buttons: left clears bit 2, middle clears bit 1, right clears bit 0. Bits 7..3 are always 5'b10000.
- R3: Byte 1 is the horizontal step `ev_dx`, after limiting, as 8-bit two's complement.
- R4: Byte 2 is the negation of the vertical step `ev_dy` after limiting, as 8-bit two's complement.
- R5: Before encoding, each step is limited to the range -127..+127. A value above +127 gives 8'h7F, a value below -127 gives 8'h81, and 8'h80 never appears in bytes 1 or 2.
- R6: Bytes 3 and 4 are both 8'h00.
- R7: An event is accepted on a clock edge where `ev_valid` and `ev_ready` are both high. `push` is then high for exactly five consecutive cycles, starting in the cycle after that edge, with bytes 0 to 4 in order on `push_data`.
- R8: `ev_ready` is low from the accepting edge until the fifth byte has been pushed, and is never high in a cycle where `push` is high. An event offered while `ev_ready` is low changes neither the packet in flight nor the number of pushes.
- R9: Once the fifth byte is pushed, `ev_ready` returns high. An event held valid is then accepted at the next edge and gives its own complete packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Encoder can take an event |
| ev_dx | input | IN_W | Signed horizontal step |
| ev_dy | input | IN_W | Signed vertical step |
| btn_left | input | 1 | Left button pressed |
| btn_mid | input | 1 | Middle button pressed |
| btn_right | input | 1 | Right button pressed |
| push | output | 1 | Push strobe to the byte FIFO |
| push_data | output | 8 | Byte pushed this cycle |

## Verification
Each button is pressed alone, then all three together, then none. This ties each cleared header bit to one button and confirms the fixed top bits. Steps inside the range, at exactly ±127, at -128 and at ±300 separate correct limiting from plain truncation and from an asymmetric range. Opposite signs on the two axes expose a missing or misplaced negation. An event held valid through a whole packet and then replaced shows whether input is ignored while busy, and whether back-to-back packets keep the five-push length and the byte order.

// File: rtl/mpk_pkg.sv
package mpk_pkg;
  localparam int BYTE_W   = 8;
  localparam int PKT_LEN  = 5;
  localparam int MOTION_N = 2;
  localparam int HDR_IDX  = 0;
  localparam int X_IDX    = 1;
  localparam int Y_IDX    = 2;
  localparam logic [BYTE_W-1:0] HDR_IDLE = 8'h87;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic left;
    logic mid;
    logic right;
  } btn_t;

  // header: released buttons keep their bit, pressed ones clear it
  function automatic byte_t hdr_byte(btn_t b);
    byte_t h;
    h    = HDR_IDLE;
    h[2] = ~b.left;
    h[1] = ~b.mid;
    h[0] = ~b.right;
    return h;
  endfunction
endpackage

// File: rtl/mpk_clamp.sv
module mpk_clamp #(
  parameter int IN_W   = 10,
  parameter int OUT_W  = 8,
  parameter bit NEGATE = 1'b0
) (
  input  logic signed [IN_W-1:0] val,
  output logic        [OUT_W-1:0] enc
);
  localparam int LIM = (1 << (OUT_W - 1)) - 1;
  localparam logic signed [IN_W-1:0] HI = IN_W'(LIM);
  localparam logic signed [IN_W-1:0] LO = -HI;

  logic signed [IN_W-1:0] sat;

  always_comb begin
    if (val > HI)      sat = HI;
    else if (val < LO) sat = LO;
    else               sat = val;
  end

  generate
    if (NEGATE) begin : g_neg
      logic signed [IN_W-1:0] neg;
      assign neg = -sat;
      assign enc = neg[OUT_W-1:0];
    end else begin : g_pos
      assign enc = sat[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/mpk_seq.sv
module mpk_seq #(
  parameter int LEN = 5,
  localparam int IDX_W = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LEN - 1);

  logic             busy_n;
  logic [IDX_W-1:0] idx_n;

  assign last = busy && (idx == LAST_IDX);

  always_comb begin
    busy_n = busy;
    idx_n  = idx;
    if (busy) begin
      if (idx == LAST_IDX) begin
        busy_n = 1'b0;
        idx_n  = '0;
      end else begin
        idx_n = idx + IDX_W'(1);
      end
    end else if (start) begin
      busy_n = 1'b1;
      idx_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else begin
      busy <= busy_n;
      idx  <= idx_n;
    end
  end

  // R7: index stays inside the packet while busy
  p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx <= LAST_IDX));
  // R7: a burst advances by one byte per cycle until its last byte
  p_burst_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && idx == $past(idx) + IDX_W'(1)));
  // R9: the last byte ends the burst
  p_burst_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);
endmodule

// File: rtl/mpk_pack.sv
module mpk_pack
  import mpk_pkg::*;
#(
  parameter int IN_W = 10,
  parameter int LEN  = PKT_LEN,
  localparam int IDX_W = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic signed [IN_W-1:0] dx,
  input  logic signed [IN_W-1:0] dy,
  input  btn_t                   btn,
  input  logic [IDX_W-1:0]       sel,
  output byte_t                  data
);
  byte_t x_enc, y_enc;
  byte_t fresh [LEN];
  byte_t slot  [LEN];

  mpk_clamp #(.IN_W(IN_W), .OUT_W(BYTE_W), .NEGATE(1'b0)) u_clx (
    .val(dx), .enc(x_enc)
  );
  mpk_clamp #(.IN_W(IN_W), .OUT_W(BYTE_W), .NEGATE(1'b1)) u_cly (
    .val(dy), .enc(y_enc)
  );

  generate
    for (genvar i = 0; i < LEN; i++) begin : g_slot
      if (i <= Y_IDX) begin : g_live
        byte_t slot_n;
        always_comb begin
          if (i == HDR_IDX)    fresh[i] = hdr_byte(btn);
          else if (i == X_IDX) fresh[i] = x_enc;
          else                 fresh[i] = y_enc;
        end
        // clock enable: capture only on accept
        assign slot_n = load ? fresh[i] : slot[i];
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) slot[i] <= '0;
          else        slot[i] <= slot_n;
        end
      end else begin : g_pad
        assign fresh[i] = '0;
        assign slot[i]  = '0;
      end
    end
  endgenerate

  always_comb begin
    data = '0;
    for (int i = 0; i < LEN; i++) begin
      if (sel == IDX_W'(i)) data = slot[i];
    end
  end
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mpk_pkg::*;
#(
  parameter int IN_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ev_valid,
  output logic                   ev_ready,
  input  logic signed [IN_W-1:0] ev_dx,
  input  logic signed [IN_W-1:0] ev_dy,
  input  logic                   btn_left,
  input  logic                   btn_mid,
  input  logic                   btn_right,
  output logic                   push,
  output logic [BYTE_W-1:0]      push_data
);
  localparam int IDX_W = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;

  logic             busy, last, accept;
  logic [IDX_W-1:0] idx;
  btn_t             btn;

  assign btn      = '{left: btn_left, mid: btn_mid, right: btn_right};
  assign ev_ready = ~busy;
  assign accept   = ev_valid & ev_ready;
  assign push     = busy;

  mpk_seq #(.LEN(PKT_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .busy(busy), .idx(idx), .last(last)
  );

  mpk_pack #(.IN_W(IN_W), .LEN(PKT_LEN)) u_pack (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .dx(ev_dx), .dy(ev_dy), .btn(btn),
    .sel(idx), .data(push_data)
  );

  // R8: no acceptance while a byte is being pushed
  p_ready_nopush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_ready && push));
  // R7: an accepted event starts its burst at the header byte
  p_accept_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready) |=> (push && idx == '0));
  // R2: header top bits are fixed
  p_hdr_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && idx == IDX_W'(HDR_IDX)) |-> (push_data[7:3] == 5'b10000));
  // R5: limited steps never reach the most negative code
  p_no_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && (idx == IDX_W'(X_IDX) || idx == IDX_W'(Y_IDX)))
      |-> (push_data != 8'h80));
  // R6: padding bytes are zero
  p_tail_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && idx > IDX_W'(Y_IDX)) |-> (push_data == '0));
endmodule

// File: tb/sim_mouse_pkt_enc.sv
module sim_mouse_pkt_enc;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic ev_ready;
  logic signed [IN_W-1:0] ev_dx = '0;
  logic signed [IN_W-1:0] ev_dy = '0;
  logic btn_left = 1'b0, btn_mid = 1'b0, btn_right = 1'b0;
  logic push;
  logic [7:0] push_data;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mouse_pkt_enc #(.IN_W(IN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_dx(ev_dx), .ev_dy(ev_dy), .btn_left(btn_left), .btn_mid(btn_mid),
    .btn_right(btn_right), .push(push), .push_data(push_data)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lim(input int v);
    int s;
    s = (v > 127) ? 127 : ((v < -127) ? -127 : v);
    return 8'(s);
  endfunction

  function automatic logic [7:0] hdr(input bit l, input bit m, input bit r);
    return {5'b10000, ~l, ~m, ~r};
  endfunction

  // checks the five pushed bytes; caller is at the negedge after acceptance
  task automatic expect_pkt(input int dx, input int dy,
                            input bit l, input bit m, input bit r,
                            input string tag);
    logic [7:0] exp [5];
    exp[0] = hdr(l, m, r);
    exp[1] = lim(dx);
    exp[2] = 8'(-int'($signed(lim(dy))));
    exp[3] = 8'h00;
    exp[4] = 8'h00;
    for (int i = 0; i < 5; i++) begin
      chk(push === 1'b1, {"R7 push ", tag}, {7'd0, push}, 8'd1);
      chk(ev_ready === 1'b0, {"R8 ready low ", tag}, {7'd0, ev_ready}, 8'd0);
      if (i == 0)      chk(push_data === exp[i], {"R2 header ", tag}, push_data, exp[i]);
      else if (i == 1) chk(push_data === exp[i], {"R3 R5 x byte ", tag}, push_data, exp[i]);
      else if (i == 2) chk(push_data === exp[i], {"R4 R5 y byte ", tag}, push_data, exp[i]);
      else             chk(push_data === exp[i], {"R6 pad byte ", tag}, push_data, exp[i]);
      @(negedge clk);
    end
  endtask

  task automatic offer(input int dx, input int dy,
                       input bit l, input bit m, input bit r);
    ev_dx = IN_W'(dx); ev_dy = IN_W'(dy);
    btn_left = l; btn_mid = m; btn_right = r;
    ev_valid = 1'b1;
  endtask

  task automatic run_pkt(input int dx, input int dy,
                         input bit l, input bit m, input bit r,
                         input string tag);
    @(negedge clk);
    chk(ev_ready === 1'b1, {"R9 ready before ", tag}, {7'd0, ev_ready}, 8'd1);
    offer(dx, dy, l, m, r);
    @(negedge clk);
    ev_valid = 1'b0;
    expect_pkt(dx, dy, l, m, r, tag);
    chk(push === 1'b0, {"R7 burst length ", tag}, {7'd0, push}, 8'd0);
    chk(ev_ready === 1'b1, {"R9 ready after ", tag}, {7'd0, ev_ready}, 8'd1);
  endtask

  // event held valid through a burst with other values: ignored, then taken
  task automatic t_busy_ignore();
    @(negedge clk);
    offer(20, -20, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    offer(-50, 60, 1'b1, 1'b1, 1'b0);
    expect_pkt(20, -20, 1'b0, 1'b0, 1'b1, "held A");
    chk(push === 1'b0, "R8 no extra push", {7'd0, push}, 8'd0);
    chk(ev_ready === 1'b1, "R9 ready for held", {7'd0, ev_ready}, 8'd1);
    @(negedge clk);
    ev_valid = 1'b0;
    expect_pkt(-50, 60, 1'b1, 1'b1, 1'b0, "held B");
    chk(push === 1'b0, "R7 burst length held B", {7'd0, push}, 8'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(push === 1'b0, "R1 reset push", {7'd0, push}, 8'd0);
    chk(ev_ready === 1'b1, "R1 reset ready", {7'd0, ev_ready}, 8'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    run_pkt(5, 3, 1'b0, 1'b0, 1'b0, "no buttons");
    run_pkt(0, 0, 1'b1, 1'b0, 1'b0, "left");
    run_pkt(0, 0, 1'b0, 1'b1, 1'b0, "middle");
    run_pkt(0, 0, 1'b0, 1'b0, 1'b1, "right");
    run_pkt(-3, -7, 1'b1, 1'b1, 1'b1, "all buttons");
    run_pkt(127, -127, 1'b0, 1'b0, 1'b0, "range edge");
    run_pkt(-128, -128, 1'b0, 1'b0, 1'b0, "minus 128");
    run_pkt(300, -300, 1'b0, 1'b0, 1'b0, "big values");
    run_pkt(-300, 300, 1'b1, 1'b0, 1'b1, "big values swapped");
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule